// File: doc/BRIEF.md
# Serial Flash Erase Command Front End

This block sits behind the serial pins of a NOR flash and turns erase commands into start requests for the array sequencer. It watches the serial clock, the active-low select and the data-in line, shifts command bits in on rising serial-clock edges while select is low, and counts those bits. When select goes high again it looks at the opcode and the bit count. From these it decides one of four outcomes: start an erase, report a protection failure, cancel the command, or do nothing.

All serial inputs are brought into the system clock domain by a synchronizer, so the block runs on one clock. Two erase kinds exist: a whole-device erase and an erase of one 64 KB sector. The block keeps a write-enable latch that must be armed before each erase, a sticky erase-failure flag and a busy flag. The busy flag covers the time from a launched erase until the array reports completion. A per-sector protection vector comes in from outside and gates every erase.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Bits are sampled most significant first on each rising edge of `sck` while `cs_n` is low. The first 8 bits form the opcode: 06h is write enable, C7h is device erase and D8h is sector erase. Any other opcode has no effect.
- R2: A write-enable frame of exactly 8 bits, while `busy` is low, sets `wel` after `cs_n` rises.
- R3: A device-erase frame of exactly 8 bits, with `wel` set and every bit of `prot` clear, produces a one-cycle `erase_req` with `erase_bulk`=1 and sets `busy`.
- R4: A sector-erase frame of exactly 32 bits (opcode then a 24-bit address) with `wel` set produces a one-cycle `erase_req` with `erase_bulk`=0 and `erase_sector` equal to address bits 23:16, provided `prot[erase_sector]` is clear. An address whose bits 23:16 are zero selects sector 0, which holds all parameter blocks.
- R5: Any erase frame received while `wel` is clear is ignored: there is no request and `wel` and `efail` are unchanged.
- R6: An erase that is correctly framed, with `wel` set, to a protected target sets `efail`, clears `wel` and issues no request. A device erase counts as protected when any bit of `prot` is set.
- R7: An erase frame whose bit count is not exactly 8 (device erase) or 32 (sector erase) is cancelled: no request, and `wel` and `efail` keep their values. Bits beyond 32 are discarded.
- R8: While `busy` is high every command is ignored. `erase_done` while busy clears `busy` and `wel` together. `erase_done` while idle has no effect.
- R9: After reset `wel`, `efail`, `busy` and `erase_req` are 0. Once set, `efail` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| prot | input | 256 | Per-sector protection, bit i protects sector i |
| erase_done | input | 1 | Array reports the erase has finished |
| erase_req | output | 1 | One-cycle erase start pulse |
| erase_bulk | output | 1 | Request is a whole-device erase |
| erase_sector | output | 8 | Sector index of the request |
| wel | output | 1 | Write-enable latch |
| efail | output | 1 | Erase-failure flag |
| busy | output | 1 | Erase in progress |

## Verification
The assertions check the following on every cycle. A start request lasts one cycle and only occurs with the latch armed and busy raised. A request never targets a protected sector, and a device erase is never requested while any protection bit is set. A failure flag that rises always takes the latch down with it. The flag never falls outside reset, and completion always leaves the latch clear. Other behaviour depends on the bit count at the moment select rises: the 7-, 9-, 31- and 33-bit cancellations, the exact sector index decoded from the address, and the ignored opcodes. Only the bench's framed scenarios can show these, and the scoreboard matches each launched request against the one it predicted.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
// Shared constants for the erase command front end: opcode values and the
// length of the opcode field. Assumes byte-wide opcodes sent MSB first.
package fe_pkg;
    localparam int OP_BITS = 8;
    localparam logic [OP_BITS-1:0] OP_WREN  = 8'h06;
    localparam logic [OP_BITS-1:0] OP_BULK  = 8'hC7;
    localparam logic [OP_BITS-1:0] OP_SECT  = 8'hD8;
endpackage

// File: rtl/fe_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent (no multi-bit coherence needed) and that
// the pin rates are well below clk so no edge is lost.
module fe_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Each stage copies the previous one; stage 0 samples the pins.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= d;
                else             stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fe_frame.sv
`timescale 1ns/1ps
// Frame capture: counts serial clock rising edges while select is low,
// latches the opcode on the 8th bit and keeps the last ADDR_W bits as the
// address. The count saturates one past the full frame, so oversized frames
// stay distinguishable. Inputs are already synchronized to clk.
module fe_frame
    import fe_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int SECTOR_W = 16,
    localparam int FRAME   = OP_BITS + ADDR_W,
    localparam int CNT_MAX = FRAME + 1,
    localparam int CNT_W   = $clog2(CNT_MAX + 1),
    localparam int SEC_W   = ADDR_W - SECTOR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               cs_s,
    input  logic               mosi_s,
    output logic               cs_rise,
    output logic [CNT_W-1:0]   cnt,
    output logic [OP_BITS-1:0] op,
    output logic [SEC_W-1:0]   sector
);
    logic              sck_q, cs_q;
    logic [ADDR_W-1:0] shreg;
    logic              sck_rise;

    assign sck_rise = sck_s & ~sck_q;
    assign cs_rise  = cs_s & ~cs_q;
    assign sector   = shreg[ADDR_W-1:SECTOR_W];

    // Edge history, bit counter, opcode latch and address shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            cnt   <= '0;
            op    <= '0;
            shreg <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
            if (cs_s) begin
                cnt <= '0;
                op  <= '0;
            end else if (sck_rise) begin
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
                if (cnt < CNT_W'(FRAME))    shreg <= {shreg[ADDR_W-2:0], mosi_s};
                if (cnt == CNT_W'(OP_BITS-1)) op <= {shreg[OP_BITS-2:0], mosi_s};
            end
        end
    end
endmodule

// File: rtl/fe_ctrl.sv
`timescale 1ns/1ps
// Command decision and status: on the select rising edge, checks opcode,
// exact bit count, the write-enable latch and protection, then launches an
// erase, flags a failure, or leaves status untouched. Holds busy until the
// array reports completion.
module fe_ctrl
    import fe_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int SECTOR_W = 16,
    localparam int FRAME   = OP_BITS + ADDR_W,
    localparam int CNT_W   = $clog2(FRAME + 2),
    localparam int SEC_W   = ADDR_W - SECTOR_W,
    localparam int NSEC    = 1 << SEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_rise,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [OP_BITS-1:0] op,
    input  logic [SEC_W-1:0]   sector,
    input  logic [NSEC-1:0]    prot,
    input  logic               erase_done,
    output logic               erase_req,
    output logic               erase_bulk,
    output logic [SEC_W-1:0]   erase_sector,
    output logic               wel,
    output logic               efail,
    output logic               busy
);
    logic is_wren, is_bulk, is_sect;

    assign is_wren = (op == OP_WREN) && (cnt == CNT_W'(OP_BITS));
    assign is_bulk = (op == OP_BULK) && (cnt == CNT_W'(OP_BITS)) && wel;
    assign is_sect = (op == OP_SECT) && (cnt == CNT_W'(FRAME)) && wel;

    // Status latch updates and erase launch on a completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_req    <= 1'b0;
            erase_bulk   <= 1'b0;
            erase_sector <= '0;
            wel          <= 1'b0;
            efail        <= 1'b0;
            busy         <= 1'b0;
        end else begin
            erase_req <= 1'b0;
            if (busy) begin
                if (erase_done) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                end
            end else if (cs_rise) begin
                if (is_wren) begin
                    wel <= 1'b1;
                end else if (is_bulk) begin
                    if (|prot) begin
                        efail <= 1'b1;
                        wel   <= 1'b0;
                    end else begin
                        erase_req    <= 1'b1;
                        erase_bulk   <= 1'b1;
                        erase_sector <= '0;
                        busy         <= 1'b1;
                    end
                end else if (is_sect) begin
                    if (prot[sector]) begin
                        efail <= 1'b1;
                        wel   <= 1'b0;
                    end else begin
                        erase_req    <= 1'b1;
                        erase_bulk   <= 1'b0;
                        erase_sector <= sector;
                        busy         <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/flash_erase_ctrl.sv
`timescale 1ns/1ps
// Top of the erase command front end. Synchronizes the serial pins, frames
// the command and decides the erase outcome. Assumes prot is stable while a
// frame completes and that erase_done is a clk-synchronous pulse.
module flash_erase_ctrl
    import fe_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SECTOR_W    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEC_W      = ADDR_W - SECTOR_W,
    localparam int NSEC       = 1 << SEC_W,
    localparam int CNT_W      = $clog2(OP_BITS + ADDR_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    input  logic [NSEC-1:0]  prot,
    input  logic             erase_done,
    output logic             erase_req,
    output logic             erase_bulk,
    output logic [SEC_W-1:0] erase_sector,
    output logic             wel,
    output logic             efail,
    output logic             busy
);
    logic [2:0]         pins_s;
    logic               cs_rise;
    logic [CNT_W-1:0]   cnt;
    logic [OP_BITS-1:0] op;
    logic [SEC_W-1:0]   sector;

    fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q(pins_s)
    );

    fe_frame #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sck_s(pins_s[2]), .cs_s(pins_s[1]), .mosi_s(pins_s[0]),
        .cs_rise(cs_rise), .cnt(cnt), .op(op), .sector(sector)
    );

    fe_ctrl #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cnt(cnt), .op(op),
        .sector(sector), .prot(prot), .erase_done(erase_done),
        .erase_req(erase_req), .erase_bulk(erase_bulk),
        .erase_sector(erase_sector), .wel(wel), .efail(efail), .busy(busy)
    );
endmodule

// File: rtl/fe_checker.sv
`timescale 1ns/1ps
// Protocol checker for flash_erase_ctrl, attached by bind below.
// Observes only the top-level ports.
module fe_checker #(
    parameter int SEC_W = 8,
    parameter int NSEC  = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSEC-1:0]  prot,
    input logic             erase_done,
    input logic             erase_req,
    input logic             erase_bulk,
    input logic [SEC_W-1:0] erase_sector,
    input logic             wel,
    input logic             efail,
    input logic             busy
);
    // R3/R4: start request is a single-cycle pulse
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);
    // R5: a request only exists with the latch armed and busy raised
    p_req_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (wel && busy));
    // R4: a sector request never targets a protected sector
    p_sect_unprot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_bulk) |-> !prot[erase_sector]);
    // R6: a device erase is never requested with any protection set
    p_bulk_unprot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_bulk) |-> (prot == '0));
    // R6: failure flag rising takes the latch down in the same cycle
    p_fail_clears_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(efail) |-> (!wel && $past(wel)));
    // R9: failure flag is sticky
    p_efail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        efail |=> efail);
    // R8: leaving busy always leaves the latch clear
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    // R8: busy only ends on a completion report
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !erase_done) |=> busy);
endmodule

bind flash_erase_ctrl fe_checker #(.SEC_W(SEC_W), .NSEC(NSEC)) u_fe_checker (
    .clk(clk), .rst_n(rst_n), .prot(prot), .erase_done(erase_done),
    .erase_req(erase_req), .erase_bulk(erase_bulk),
    .erase_sector(erase_sector), .wel(wel), .efail(efail), .busy(busy)
);

// File: tb/tb_flash_erase_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each launch into a queue, the
// monitor pops and compares whenever the design issues a request.
module tb_flash_erase_ctrl;
    localparam int HALF = 3;   // clk cycles per serial half period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [255:0] prot = '0;
    logic         erase_done = 1'b0;
    logic         erase_req, erase_bulk, wel, efail, busy;
    logic [7:0]   erase_sector;

    int checks = 0;
    int fails  = 0;
    logic [8:0] exp_q [$];     // {bulk, sector}
    int launches = 0;

    always #5 clk = ~clk;

    flash_erase_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .prot(prot), .erase_done(erase_done), .erase_req(erase_req),
        .erase_bulk(erase_bulk), .erase_sector(erase_sector), .wel(wel),
        .efail(efail), .busy(busy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic status(input string req, input logic ew, input logic ef,
                          input logic eb);
        check(req, "wel", wel, ew);
        check(req, "efail", efail, ef);
        check(req, "busy", busy, eb);
    endtask

    // Drive one frame of n bits, MSB first from bits[39].
    task automatic send(input logic [39:0] bits, input int n);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = bits[39-i];
            sck  = 1'b0;
            repeat (HALF) @(negedge clk);
            sck  = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic op8(input logic [7:0] op, input int n);
        send({op, 32'h0}, n);
    endtask

    task automatic sect(input logic [23:0] addr, input int n);
        send({8'hD8, addr, 8'h0}, n);
    endtask

    task automatic done_pulse();
        @(negedge clk) erase_done = 1'b1;
        @(negedge clk) erase_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare each request against the predicted launch.
    always @(negedge clk) begin
        if (rst_n && erase_req) begin
            launches++;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected request: actual bulk=%0b sector=%0h expected none",
                         erase_bulk, erase_sector);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(e[8] ? "R3" : "R4", "request", {erase_bulk, erase_sector}, e);
            end
        end
    end

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        status("R9", 0, 0, 0);
        check("R9", "erase_req", erase_req, 0);

        // R5: erases with the latch clear do nothing
        op8(8'hC7, 8);
        status("R5", 0, 0, 0);
        sect(24'h030000, 32);
        status("R5", 0, 0, 0);

        // R2: write enable arms the latch
        op8(8'h06, 8);
        status("R2", 1, 0, 0);

        // R7: 7 and 9 bit device-erase frames cancel
        op8(8'hC7, 7);
        status("R7", 1, 0, 0);
        op8(8'hC7, 9);
        status("R7", 1, 0, 0);

        // R3: correct device erase launches
        exp_q.push_back({1'b1, 8'h00});
        op8(8'hC7, 8);
        status("R3", 1, 0, 1);

        // R8: commands while busy are ignored
        sect(24'h020000, 32);
        op8(8'h06, 8);
        status("R8", 1, 0, 1);
        done_pulse();
        status("R8", 0, 0, 0);
        done_pulse();   // idle completion has no effect
        status("R8", 0, 0, 0);

        // R7: 31 and 33 bit sector frames cancel
        op8(8'h06, 8);
        sect(24'h051234, 31);
        status("R7", 1, 0, 0);
        sect(24'h051234, 33);
        status("R7", 1, 0, 0);

        // R4: sector 5 erase
        exp_q.push_back({1'b0, 8'h05});
        sect(24'h051234, 32);
        status("R4", 1, 0, 1);
        done_pulse();

        // R4: parameter region maps to sector 0
        op8(8'h06, 8);
        exp_q.push_back({1'b0, 8'h00});
        sect(24'h00ABCD, 32);
        status("R4", 1, 0, 1);
        done_pulse();

        // R1: unknown opcode ignored, latch kept
        op8(8'h06, 8);
        op8(8'h20, 8);
        status("R1", 1, 0, 0);

        // R6: protected sector fails
        prot[9] = 1'b1;
        sect(24'h09FFFF, 32);
        status("R6", 0, 1, 0);

        // R6: device erase with any protection fails; R9 flag stays
        op8(8'h06, 8);
        op8(8'hC7, 8);
        status("R6", 0, 1, 0);

        // R4/R9: unprotected sector still erases, flag still set
        op8(8'h06, 8);
        exp_q.push_back({1'b0, 8'hFE});
        sect(24'hFE0000, 32);
        status("R9", 1, 1, 1);
        done_pulse();

        check("R3", "pending predictions", exp_q.size(), 0);
        check("R4", "launch count", launches, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule